// File: doc/BRIEF.md
# Scan Width Adapter

This block joins a P-bit network data port to N wrapper scan chains when P and N are unrelated. On the input side, data words enter a bit accumulator. Each scan shift takes the N lowest buffered bits, one per chain. On the output side, the N serial scan-out bits taken at each shift are packed into P-bit words for the output data port. Every port bit carries scan data, so the bits of one word are spread over several shifts and across word boundaries. The network bandwidth needed is N bits per scan cycle, which is the scan bandwidth itself.

Shifting is gated by `scan_en_o`. The downstream chains shift on a clock edge where it is high, and the chain outputs present in that cycle are captured. Shifting stalls when fewer than N input bits are buffered or when the output packer has no room. When input is continuous and the output is always ready, the adapter adds no idle shift cycles. At the end of a pattern, a flush request sends out any partly filled output word, padded with zeros.

Top module: `scan_width_adapter`

## Requirements
- R1: While reset is asserted, `in_ready_o` is 1, `scan_en_o` is 0 and `out_valid_o` is 0.
- R2: The input words, taken in acceptance order with bit 0 of each word first, form one serial stream. On the k-th shift (k counted from 0), `scan_si_o[c]` carries stream bit k*N+c.
- R3: A word is taken on a cycle where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high only if the word fits alongside the bits still held after this cycle's shift, so no accepted bit is lost or overwritten.
- R4: `scan_en_o` stays low whenever fewer than N input bits are buffered. From W accepted words, exactly floor(W*P/N) shifts occur.
- R5: The serial output stream is `scan_so_i` sampled on each shift, with chain c of shift k at position k*N+c. Output word j carries positions j*P to j*P+P-1, with bit 0 of the word being the lowest position.
- R6: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` holds its value on the next cycle.
- R7: A one-cycle `flush_i` pulse makes all buffered output bits leave, with the last partial word zero-padded above its valid bits. A flush with nothing buffered produces no word. Shifting pauses until the flush has drained.
- R8: With words offered on every cycle and `out_ready_i` held high, `scan_en_o` stays high on every cycle after the first shift for as long as input bits remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_data_i | input | P_W | Incoming data word |
| in_valid_i | input | 1 | Incoming word valid |
| in_ready_o | output | 1 | Adapter can take a word this cycle |
| scan_en_o | output | 1 | Shift all chains by one this cycle |
| scan_si_o | output | N_CH | Serial input bit per chain |
| scan_so_i | input | N_CH | Serial output bit per chain |
| out_data_o | output | P_W | Packed outgoing word |
| out_valid_o | output | 1 | Outgoing word valid |
| out_ready_i | input | 1 | Receiver takes the word |
| flush_i | input | 1 | Emit the partial output word |

## Verification
On every cycle, assertions check the occupancy bounds of both buffers. They also check that no shift occurs with fewer than N input bits, that an accepted word without a shift raises the occupancy by P, and that a word held off by backpressure stays stable. They further check that no shift occurs while a flush drains. Only the bench scenarios can show that bit ordering, word spreading across shifts and the zero padding of the final word are correct. These scenarios run random and back-to-back traffic at N of 3, 5, 8 and 12 against a stream model, and they also show that the shift stream has no bubbles under continuous traffic.

// File: rtl/scan_adapter_pkg.sv
package scan_adapter_pkg;
  function automatic int unsigned cnt_w(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/sa_in_accum.sv
module sa_in_accum
  import scan_adapter_pkg::*;
#(
  parameter int unsigned P_W  = 32,
  parameter int unsigned N_CH = 3,
  localparam int unsigned D   = P_W + N_CH,
  localparam int unsigned CW  = cnt_w(D)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [P_W-1:0]  word_i,
  input  logic            push_i,
  input  logic            shift_i,
  output logic            ready_o,
  output logic [CW-1:0]   cnt_o,
  output logic [N_CH-1:0] bits_o
);
  logic [D-1:0]  acc_q, acc_d, base, ins;
  logic [CW-1:0] cnt_q, cnt_d, base_cnt;

  // free space after this cycle's shift must hold a whole word
  assign ready_o = cnt_q <= (shift_i ? CW'(2 * N_CH) : CW'(N_CH));
  assign cnt_o   = cnt_q;
  assign bits_o  = acc_q[N_CH-1:0];

  always_comb begin
    base     = shift_i ? (acc_q >> N_CH) : acc_q;
    base_cnt = shift_i ? cnt_q - CW'(N_CH) : cnt_q;
    ins      = {{N_CH{1'b0}}, word_i} << base_cnt;
    acc_d    = push_i ? (base | ins) : base;
    cnt_d    = base_cnt + (push_i ? CW'(P_W) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R3
  in_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(D));
  // R3
  in_accept_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !shift_i) |=> cnt_q == $past(cnt_q) + CW'(P_W));
  // R4
  in_enough_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> cnt_q >= CW'(N_CH));
endmodule

// File: rtl/sa_out_pack.sv
module sa_out_pack
  import scan_adapter_pkg::*;
#(
  parameter int unsigned P_W  = 32,
  parameter int unsigned N_CH = 3,
  localparam int unsigned D   = P_W + N_CH,
  localparam int unsigned CW  = cnt_w(D)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] bits_i,
  input  logic            shift_i,
  input  logic            flush_i,
  input  logic            pop_i,
  output logic            room_o,
  output logic            busy_o,
  output logic            valid_o,
  output logic [P_W-1:0]  word_o
);
  logic [D-1:0]  acc_q, acc_d, base, ins;
  logic [CW-1:0] cnt_q, cnt_d, base_cnt;
  logic          fl_q, fl_d;

  assign room_o  = (cnt_q < CW'(P_W)) || pop_i;
  assign busy_o  = fl_q;
  assign valid_o = (cnt_q >= CW'(P_W)) || (fl_q && cnt_q != '0);
  assign word_o  = acc_q[P_W-1:0];

  always_comb begin
    base     = acc_q;
    base_cnt = cnt_q;
    if (pop_i) begin
      if (cnt_q >= CW'(P_W)) begin
        base     = acc_q >> P_W;
        base_cnt = cnt_q - CW'(P_W);
      end else begin
        base     = '0;
        base_cnt = '0;
      end
    end
    ins   = {{P_W{1'b0}}, bits_i} << base_cnt;
    acc_d = shift_i ? (base | ins) : base;
    cnt_d = base_cnt + (shift_i ? CW'(N_CH) : '0);
    fl_d  = (fl_q || flush_i) && (cnt_d != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      fl_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      fl_q  <= fl_d;
    end
  end

  // R5
  out_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(D));
  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(word_o)));
  // R7
  flush_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_q |-> !shift_i);
endmodule

// File: rtl/scan_width_adapter.sv
module scan_width_adapter
  import scan_adapter_pkg::*;
#(
  parameter int unsigned P_W  = 32,
  parameter int unsigned N_CH = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [P_W-1:0]  in_data_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  output logic            scan_en_o,
  output logic [N_CH-1:0] scan_si_o,
  input  logic [N_CH-1:0] scan_so_i,
  output logic [P_W-1:0]  out_data_o,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  input  logic            flush_i
);
  localparam int unsigned CW = cnt_w(P_W + N_CH);

  logic [CW-1:0] in_cnt;
  logic          out_room, out_busy, push, pop;

  assign scan_en_o = (in_cnt >= CW'(N_CH)) && out_room && !out_busy;
  assign push      = in_valid_i && in_ready_o;
  assign pop       = out_valid_o && out_ready_i;

  sa_in_accum #(.P_W(P_W), .N_CH(N_CH)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .word_i  (in_data_i),
    .push_i  (push),
    .shift_i (scan_en_o),
    .ready_o (in_ready_o),
    .cnt_o   (in_cnt),
    .bits_o  (scan_si_o)
  );

  sa_out_pack #(.P_W(P_W), .N_CH(N_CH)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bits_i  (scan_so_i),
    .shift_i (scan_en_o),
    .flush_i (flush_i),
    .pop_i   (pop),
    .room_o  (out_room),
    .busy_o  (out_busy),
    .valid_o (out_valid_o),
    .word_o  (out_data_o)
  );
endmodule

// File: tb/scan_width_adapter_tb_top.sv
`timescale 1ns/1ps

module sa_harness #(
  parameter int unsigned P_W   = 32,
  parameter int unsigned N_CH  = 3,
  parameter int unsigned WORDS = 121
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o,
  output int   checks_o,
  output int   fails_o
);
  localparam int K_TOT = (WORDS * P_W) / N_CH;
  localparam int J_TOT = (K_TOT * N_CH + P_W - 1) / P_W;
  localparam int KA    = (20 * P_W) / N_CH;

  logic [P_W-1:0]  in_data, out_data;
  logic            in_valid, in_ready, scan_en, out_valid, out_ready, flush;
  logic [N_CH-1:0] scan_si, scan_so;
  logic [P_W-1:0]  in_words [WORDS];

  scan_width_adapter #(.P_W(P_W), .N_CH(N_CH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .scan_en_o(scan_en), .scan_si_o(scan_si), .scan_so_i(scan_so),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .flush_i(flush)
  );

  function automatic logic [N_CH-1:0] so_hash(input int k);
    logic [31:0] h;
    h = 32'(k) * 32'h9E3779B1;
    h = h ^ (h >> 13);
    return N_CH'(h);
  endfunction

  function automatic logic exp_in(input int pos);
    return in_words[pos / P_W][pos % P_W];
  endfunction

  function automatic logic exp_out(input int pos);
    logic [N_CH-1:0] v;
    if (pos >= K_TOT * N_CH) return 1'b0;
    v = so_hash(pos / N_CH);
    return v[pos % N_CH];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks_o++;
    if (!ok) begin
      fails_o++;
      $display("FAIL %s n=%0d actual=%0h expected=%0h", req, N_CH, act, exp);
    end
  endtask

  initial begin
    int k, wsent, j, bubbles;
    bit flushed, held;
    logic [P_W-1:0] held_data, ew;
    logic [N_CH-1:0] es;
    done_o = 0; checks_o = 0; fails_o = 0;
    in_valid = 0; in_data = '0; out_ready = 0; flush = 0; scan_so = '0;
    void'($urandom(1000 + N_CH));
    for (int i = 0; i < WORDS; i++) in_words[i] = $urandom;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(in_ready == 1 && scan_en == 0 && out_valid == 0, "R1",
        {in_ready, scan_en, out_valid}, 3'b100);
    wait (rst_n);
    @(negedge clk);
    flush = 1;  // R7 empty flush
    @(negedge clk);
    flush = 0;
    #1;
    chk(out_valid == 0, "R7 empty flush", out_valid, 0);
    k = 0; wsent = 0; j = 0; bubbles = 0; flushed = 0; held = 0;
    while (!(flushed && j == J_TOT)) begin
      @(negedge clk);
      in_valid  = (wsent < WORDS) && ((wsent < 20) || ($urandom % 10 < 7));
      in_data   = (wsent < WORDS) ? in_words[wsent] : '0;
      out_ready = (k < KA) || ($urandom % 10 < 8);
      scan_so   = so_hash(k);
      flush     = 0;
      if (!flushed && k == K_TOT && wsent == WORDS) begin
        flush = 1;
        flushed = 1;
      end
      #1;
      if (held) begin
        // R6 held word
        chk(out_valid && out_data == held_data, "R6", out_data, held_data);
        held = 0;
      end
      if (scan_en) begin
        if (k >= K_TOT) chk(0, "R4 extra shift", k, K_TOT);
        else begin
          for (int c = 0; c < N_CH; c++) es[c] = exp_in(k * N_CH + c);
          chk(scan_si == es, "R2", scan_si, es);  // R2 bit ordering
        end
        k++;
      end else if (k >= 1 && k < KA) bubbles++;
      if (in_valid && in_ready) wsent++;
      if (out_valid && out_ready) begin
        for (int b = 0; b < P_W; b++) ew[b] = exp_out(j * P_W + b);
        chk(out_data == ew, (j == J_TOT - 1) ? "R7 last word" : "R5", out_data, ew);
        j++;
      end else if (out_valid) begin
        held = 1;
        held_data = out_data;
      end
    end
    in_valid = 0; out_ready = 1; flush = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #1;
      chk(scan_en == 0 && out_valid == 0, "R4 idle after end", {scan_en, out_valid}, 0);
    end
    chk(k == K_TOT, "R4 shift count", k, K_TOT);
    chk(wsent == WORDS, "R3 words taken", wsent, WORDS);
    chk(bubbles == 0, "R8 no bubbles", bubbles, 0);
    done_o = 1;
  end
endmodule

module scan_width_adapter_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] done;
  int c3, c5, c8, c12, f3, f5, f8, f12;

  always #10 clk = ~clk;

  sa_harness #(.N_CH(3))  h3  (.clk(clk), .rst_n(rst_n), .done_o(done[0]), .checks_o(c3),  .fails_o(f3));
  sa_harness #(.N_CH(5))  h5  (.clk(clk), .rst_n(rst_n), .done_o(done[1]), .checks_o(c5),  .fails_o(f5));
  sa_harness #(.N_CH(8))  h8  (.clk(clk), .rst_n(rst_n), .done_o(done[2]), .checks_o(c8),  .fails_o(f8));
  sa_harness #(.N_CH(12)) h12 (.clk(clk), .rst_n(rst_n), .done_o(done[3]), .checks_o(c12), .fails_o(f12));

  initial begin
    int cyc, tot_c, tot_f;
    cyc = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    while (done != 4'hF && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    #1;
    tot_c = c3 + c5 + c8 + c12;
    tot_f = f3 + f5 + f8 + f12;
    if (done != 4'hF) begin
      tot_c++;
      tot_f++;
      $display("FAIL watchdog actual=%0h expected=f", done);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", tot_c, tot_f);
    $finish;
  end
endmodule